// File: doc/BRIEF.md
# Repeater Management Serial Command Port

This block is the command front end of a multi-port repeater's management logic. An external controller clocks command bytes into a single serial input on the rising edge of the management clock. Each byte travels in asynchronous-serial framing: a low start bit, then eight data bits with the least significant bit first. When the last data bit arrives, the block decodes the byte and updates its control registers. These registers cover per-port enable, per-port link-test enable, per-port automatic polarity correction, AUI port enable, the reconnection policy for the AUI port and for the twisted-pair ports, and three option bits.

Read opcodes return one status byte on the serial output in the same framing. The status can be link, polarity, partition or rate-error state of the eight twisted-pair ports, the AUI port status, or the jabber-inhibit flag. Several AUI flags and the jabber flag are sticky. Each is set by a one-cycle event input and cleared by the read opcodes that select it. The link, polarity and partition status bits are taken directly from the port logic. Opcodes that the block does not recognise have no effect and produce no reply.

Top module: `repmgmt_serial_ctrl`

## Requirements
- R1: A command starts when `serIn` is sampled low in idle (start bit). The next eight rising edges sample data bits 0 to 7, least significant bit first.
- R2: For a read, `serOut` drives a low start bit from the edge that samples data bit 7. The eight reply bits follow, least significant first, one per clock, and the line then returns high. `serOut` rests high, and `serIn` is ignored while a reply is being sent.
- R3: The reply to 0xD0 is the link-good vector, to 0xE0 the polarity-reversed vector, to 0x80 the connected vector, and to 0x8E the rate-error vector. Reply bit n is twisted-pair port n.
- R4: 0b00110ppp sets and 0b00100ppp clears the enable of twisted-pair port ppp. No other port's bit changes.
- R5: 0b01010ppp sets and 0b01000ppp clears the link-test enable of port ppp. 0b01110ppp sets and 0b01100ppp clears its auto-polarity enable.
- R6: 0x3F sets `auiEnable` and 0x2F clears it.
- R7: 0x1F sets `auiAltRecon` and 0x10 sets `tpAltRecon`. Once set, both stay set until reset.
- R8: The AUI status reply is {partitioned, rate-error, SQE, loop-error, 0000} from bit 7 down to bit 0. The last three bits are sticky flags set by their event inputs. The partition bit follows `auiPartitioned`.
- R9: 0x8F clears the rate-error, SQE and loop-error flags after reading them. 0x8B clears SQE and loop-error, 0x8D clears only rate-error, and 0x89 clears nothing. The partition bit is never cleared.
- R10: 0xF0 replies {jabber flag, 0000000} and clears the sticky jabber flag, which `jabberEv` sets.
- R11: 0b00001xyz writes xyz into `optionBits`.
- R12: After reset, all port enables, link-test enables and auto-polarity enables are 1, `auiEnable` is 1, both policy selects are 0, `optionBits` is 0 and `serOut` is 1.
- R13: An unrecognised opcode changes no register and produces no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; serial data sampled on rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Serial command input |
| tpLinkGood | input | 8 | Link-good status per twisted-pair port |
| tpPolRev | input | 8 | Polarity-reversed status per port |
| tpConnected | input | 8 | Connected (not partitioned) status per port |
| tpRateErr | input | 8 | Rate-error status per port |
| auiPartitioned | input | 1 | AUI port partition state |
| auiRateErrEv | input | 1 | One-cycle AUI rate-error event |
| auiSqeEv | input | 1 | One-cycle AUI SQE event |
| auiLoopErrEv | input | 1 | One-cycle AUI loopback-error event |
| jabberEv | input | 1 | One-cycle jabber-inhibit event |
| serOut | output | 1 | Serial reply output |
| tpEnable | output | 8 | Per-port enable |
| tpLinkTestEn | output | 8 | Per-port link-test enable |
| tpAutoPolEn | output | 8 | Per-port auto-polarity enable |
| auiEnable | output | 1 | AUI port enable |
| auiAltRecon | output | 1 | AUI alternative reconnection policy select |
| tpAltRecon | output | 1 | Twisted-pair alternative reconnection policy select |
| optionBits | output | 3 | Option bits |

## Verification
The bench drives the read opcodes against distinct status patterns, so a design that sends most significant bit first, or that starts the reply one clock early or late, shows a shifted or mirrored frame. The port-select writes check that only one bit moves, which catches a wrong decode of the 3-bit field or a mask that clears neighbours. The AUI clear-mask sequence reads the flags back after each variant, which exposes a swapped clear bit or a cleared partition bit. A noise frame is driven on the input during a reply, and an unrecognised byte is sent. A design that listens while it transmits, or that acts on unknown opcodes, then changes a register or sends a reply.

// File: rtl/repmgmt_pkg.sv
package repmgmt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RX   = 2'd1,
    SEQ_TX   = 2'd2
  } seqState_t;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic rxShift;   // sample one data bit of the command
    logic cmdDone;   // final data bit sampled this edge: execute
    logic txLoad;    // begin reply: drive start bit, load word
    logic txShift;   // drive next reply bit
  } seqStrobe_t;
endpackage

// File: rtl/repmgmt_seq.sv
module repmgmt_seq
  import repmgmt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serIn,
  input  logic       cmdIsRead,
  output seqStrobe_t strb
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(DATA_W);

  seqState_t        state;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strb = '0;
    case (state)
      SEQ_RX: begin
        strb.rxShift = 1'b1;
        if (bitCnt == LAST_RX) begin
          strb.cmdDone = 1'b1;
          strb.txLoad  = cmdIsRead;
        end
      end
      SEQ_TX:  strb.txShift = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= SEQ_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          bitCnt <= '0;
          if (!serIn) state <= SEQ_RX;
        end
        SEQ_RX: begin
          if (bitCnt == LAST_RX) begin
            bitCnt <= '0;
            state  <= cmdIsRead ? SEQ_TX : SEQ_IDLE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        SEQ_TX: begin
          if (bitCnt == LAST_TX) begin
            bitCnt <= '0;
            state  <= SEQ_IDLE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/repmgmt_regs.sv
module repmgmt_regs
  import repmgmt_pkg::*;
#(
  parameter int unsigned NUM_TP = 8,
  parameter int unsigned OPT_W  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  seqStrobe_t        strb,
  input  logic [NUM_TP-1:0] tpLinkGood,
  input  logic [NUM_TP-1:0] tpPolRev,
  input  logic [NUM_TP-1:0] tpConnected,
  input  logic [NUM_TP-1:0] tpRateErr,
  input  logic              auiPartitioned,
  input  logic              auiRateErrEv,
  input  logic              auiSqeEv,
  input  logic              auiLoopErrEv,
  input  logic              jabberEv,
  output logic              cmdIsRead,
  output logic              serOut,
  output logic [NUM_TP-1:0] tpEnable,
  output logic [NUM_TP-1:0] tpLinkTestEn,
  output logic [NUM_TP-1:0] tpAutoPolEn,
  output logic              auiEnable,
  output logic              auiAltRecon,
  output logic              tpAltRecon,
  output logic [OPT_W-1:0]  optionBits
);
  localparam int unsigned SEL_W = $clog2(NUM_TP);
  localparam int unsigned HI_W  = DATA_W - SEL_W;

  logic [DATA_W-1:0] rxSr;
  logic [DATA_W-1:0] cmdByte;
  logic [DATA_W-1:0] txSr;
  logic [DATA_W-1:0] reply;
  logic [HI_W-1:0]   hiField;
  logic [SEL_W-1:0]  portSel;
  logic [NUM_TP-1:0] portMask;

  logic stB, stS, stL, stJab;
  logic clrB, clrSL, clrJab;
  logic enSet, enClr, ltSet, ltClr, apSet, apClr;
  logic auiSet, auiClr, auiAltSet, tpAltSet, optWr;

  // byte as it stands once the final data bit is taken
  assign cmdByte  = {serIn, rxSr[DATA_W-1:1]};
  assign hiField  = cmdByte[DATA_W-1:SEL_W];
  assign portSel  = cmdByte[SEL_W-1:0];
  assign portMask = NUM_TP'(1) << portSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxSr <= '0;
    else if (strb.rxShift) rxSr <= cmdByte;
  end

  // opcode decode
  always_comb begin
    cmdIsRead = 1'b0;
    reply     = '0;
    clrB      = 1'b0;
    clrSL     = 1'b0;
    clrJab    = 1'b0;
    enSet     = 1'b0;
    enClr     = 1'b0;
    ltSet     = 1'b0;
    ltClr     = 1'b0;
    apSet     = 1'b0;
    apClr     = 1'b0;
    auiSet    = 1'b0;
    auiClr    = 1'b0;
    auiAltSet = 1'b0;
    tpAltSet  = 1'b0;
    optWr     = 1'b0;
    case (cmdByte)
      8'hD0: begin cmdIsRead = 1'b1; reply = DATA_W'(tpLinkGood);  end
      8'hE0: begin cmdIsRead = 1'b1; reply = DATA_W'(tpPolRev);    end
      8'h80: begin cmdIsRead = 1'b1; reply = DATA_W'(tpConnected); end
      8'h8E: begin cmdIsRead = 1'b1; reply = DATA_W'(tpRateErr);   end
      8'hF0: begin
        cmdIsRead = 1'b1;
        reply     = {stJab, {(DATA_W-1){1'b0}}};
        clrJab    = 1'b1;
      end
      8'h89, 8'h8B, 8'h8D, 8'h8F: begin
        cmdIsRead = 1'b1;
        reply     = {auiPartitioned, stB, stS, stL, {(DATA_W-4){1'b0}}};
        clrB      = cmdByte[2];
        clrSL     = cmdByte[1];
      end
      8'h3F: auiSet    = 1'b1;
      8'h2F: auiClr    = 1'b1;
      8'h1F: auiAltSet = 1'b1;
      8'h10: tpAltSet  = 1'b1;
      default: begin
        case (hiField)
          5'b00110: enSet = 1'b1;
          5'b00100: enClr = 1'b1;
          5'b01010: ltSet = 1'b1;
          5'b01000: ltClr = 1'b1;
          5'b01110: apSet = 1'b1;
          5'b01100: apClr = 1'b1;
          5'b00001: optWr = 1'b1;
          default:  ;
        endcase
      end
    endcase
  end

  // per-port control bits
  for (genvar g = 0; g < NUM_TP; g++) begin : gPort
    logic hit;
    assign hit = strb.cmdDone & portMask[g];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tpEnable[g]     <= 1'b1;
        tpLinkTestEn[g] <= 1'b1;
        tpAutoPolEn[g]  <= 1'b1;
      end else if (hit) begin
        if (enSet)      tpEnable[g]     <= 1'b1;
        else if (enClr) tpEnable[g]     <= 1'b0;
        if (ltSet)      tpLinkTestEn[g] <= 1'b1;
        else if (ltClr) tpLinkTestEn[g] <= 1'b0;
        if (apSet)      tpAutoPolEn[g]  <= 1'b1;
        else if (apClr) tpAutoPolEn[g]  <= 1'b0;
      end
    end
  end

  // global control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      auiEnable   <= 1'b1;
      auiAltRecon <= 1'b0;
      tpAltRecon  <= 1'b0;
      optionBits  <= '0;
    end else if (strb.cmdDone) begin
      if (auiSet)    auiEnable   <= 1'b1;
      if (auiClr)    auiEnable   <= 1'b0;
      if (auiAltSet) auiAltRecon <= 1'b1;
      if (tpAltSet)  tpAltRecon  <= 1'b1;
      if (optWr)     optionBits  <= cmdByte[OPT_W-1:0];
    end
  end

  // sticky flags: a new event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stB   <= 1'b0;
      stS   <= 1'b0;
      stL   <= 1'b0;
      stJab <= 1'b0;
    end else begin
      stB   <= auiRateErrEv | (stB   & ~(strb.cmdDone & clrB));
      stS   <= auiSqeEv     | (stS   & ~(strb.cmdDone & clrSL));
      stL   <= auiLoopErrEv | (stL   & ~(strb.cmdDone & clrSL));
      stJab <= jabberEv     | (stJab & ~(strb.cmdDone & clrJab));
    end
  end

  // reply shifter, refilled with ones so the line rests high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serOut <= 1'b1;
      txSr   <= '1;
    end else if (strb.txLoad) begin
      serOut <= 1'b0;
      txSr   <= reply;
    end else if (strb.txShift) begin
      serOut <= txSr[0];
      txSr   <= {1'b1, txSr[DATA_W-1:1]};
    end
  end
endmodule

// File: rtl/repmgmt_serial_ctrl.sv
module repmgmt_serial_ctrl
  import repmgmt_pkg::*;
#(
  parameter int unsigned NUM_TP = 8,
  parameter int unsigned OPT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic [NUM_TP-1:0] tpLinkGood,
  input  logic [NUM_TP-1:0] tpPolRev,
  input  logic [NUM_TP-1:0] tpConnected,
  input  logic [NUM_TP-1:0] tpRateErr,
  input  logic              auiPartitioned,
  input  logic              auiRateErrEv,
  input  logic              auiSqeEv,
  input  logic              auiLoopErrEv,
  input  logic              jabberEv,
  output logic              serOut,
  output logic [NUM_TP-1:0] tpEnable,
  output logic [NUM_TP-1:0] tpLinkTestEn,
  output logic [NUM_TP-1:0] tpAutoPolEn,
  output logic              auiEnable,
  output logic              auiAltRecon,
  output logic              tpAltRecon,
  output logic [OPT_W-1:0]  optionBits
);
  seqStrobe_t seqStrb;
  logic       cmdIsRead;

  repmgmt_seq #(.DATA_W(BYTE_W)) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .cmdIsRead(cmdIsRead),
    .strb     (seqStrb)
  );

  repmgmt_regs #(.NUM_TP(NUM_TP), .OPT_W(OPT_W), .DATA_W(BYTE_W)) u_regs (
    .clk           (clk),
    .rstN          (rstN),
    .serIn         (serIn),
    .strb          (seqStrb),
    .tpLinkGood    (tpLinkGood),
    .tpPolRev      (tpPolRev),
    .tpConnected   (tpConnected),
    .tpRateErr     (tpRateErr),
    .auiPartitioned(auiPartitioned),
    .auiRateErrEv  (auiRateErrEv),
    .auiSqeEv      (auiSqeEv),
    .auiLoopErrEv  (auiLoopErrEv),
    .jabberEv      (jabberEv),
    .cmdIsRead     (cmdIsRead),
    .serOut        (serOut),
    .tpEnable      (tpEnable),
    .tpLinkTestEn  (tpLinkTestEn),
    .tpAutoPolEn   (tpAutoPolEn),
    .auiEnable     (auiEnable),
    .auiAltRecon   (auiAltRecon),
    .tpAltRecon    (tpAltRecon),
    .optionBits    (optionBits)
  );
endmodule

// File: rtl/repmgmt_serial_ctrl_chk.sv
module repmgmt_serial_ctrl_chk
  import repmgmt_pkg::*;
#(
  parameter int unsigned NUM_TP = 8,
  parameter int unsigned OPT_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input seqStrobe_t        seqStrb,
  input logic              serOut,
  input logic [NUM_TP-1:0] tpEnable,
  input logic [NUM_TP-1:0] tpLinkTestEn,
  input logic [NUM_TP-1:0] tpAutoPolEn,
  input logic              auiEnable,
  input logic              auiAltRecon,
  input logic              tpAltRecon,
  input logic [OPT_W-1:0]  optionBits
);
  assert_reply_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    seqStrb.txLoad |=> !serOut);

  assert_reply_after_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    seqStrb.txLoad |-> seqStrb.cmdDone);

  assert_no_listen_while_send_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({seqStrb.rxShift, seqStrb.txShift}));

  assert_hold_without_cmd_R13: assert property (@(posedge clk) disable iff (!rstN)
    !seqStrb.cmdDone |=> ($stable(tpEnable) && $stable(tpLinkTestEn) &&
                          $stable(tpAutoPolEn) && $stable(auiEnable) &&
                          $stable(optionBits)));

  assert_one_port_moves_R4: assert property (@(posedge clk) disable iff (!rstN)
    seqStrb.cmdDone |=> ($countones(tpEnable ^ $past(tpEnable)) <= 1));

  assert_aui_alt_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    auiAltRecon |=> auiAltRecon);

  assert_tp_alt_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    tpAltRecon |=> tpAltRecon);
endmodule

bind repmgmt_serial_ctrl repmgmt_serial_ctrl_chk #(.NUM_TP(NUM_TP), .OPT_W(OPT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .seqStrb     (seqStrb),
  .serOut      (serOut),
  .tpEnable    (tpEnable),
  .tpLinkTestEn(tpLinkTestEn),
  .tpAutoPolEn (tpAutoPolEn),
  .auiEnable   (auiEnable),
  .auiAltRecon (auiAltRecon),
  .tpAltRecon  (tpAltRecon),
  .optionBits  (optionBits)
);

// File: tb/sim_repmgmt_serial_ctrl.sv
`timescale 1ns/1ps
module sim_repmgmt_serial_ctrl;
  logic       clk = 1'b0;
  logic       rstN;
  logic       serIn;
  logic [7:0] tpLinkGood, tpPolRev, tpConnected, tpRateErr;
  logic       auiPartitioned, auiRateErrEv, auiSqeEv, auiLoopErrEv, jabberEv;
  logic       serOut;
  logic [7:0] tpEnable, tpLinkTestEn, tpAutoPolEn;
  logic       auiEnable, auiAltRecon, tpAltRecon;
  logic [2:0] optionBits;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  repmgmt_serial_ctrl u0 (
    .clk(clk), .rstN(rstN), .serIn(serIn),
    .tpLinkGood(tpLinkGood), .tpPolRev(tpPolRev), .tpConnected(tpConnected),
    .tpRateErr(tpRateErr), .auiPartitioned(auiPartitioned),
    .auiRateErrEv(auiRateErrEv), .auiSqeEv(auiSqeEv), .auiLoopErrEv(auiLoopErrEv),
    .jabberEv(jabberEv), .serOut(serOut), .tpEnable(tpEnable),
    .tpLinkTestEn(tpLinkTestEn), .tpAutoPolEn(tpAutoPolEn), .auiEnable(auiEnable),
    .auiAltRecon(auiAltRecon), .tpAltRecon(tpAltRecon), .optionBits(optionBits)
  );

  // row: {opcode, hasReply, reply, tpEnable, tpLinkTestEn, tpAutoPolEn}
  localparam int NVEC = 14;
  localparam logic [40:0] VEC [NVEC] = '{
    {8'hD0, 1'b1, 8'hA5, 8'hFF, 8'hFF, 8'hFF},
    {8'hE0, 1'b1, 8'h3C, 8'hFF, 8'hFF, 8'hFF},
    {8'h80, 1'b1, 8'hF0, 8'hFF, 8'hFF, 8'hFF},
    {8'h8E, 1'b1, 8'h81, 8'hFF, 8'hFF, 8'hFF},
    {8'h23, 1'b0, 8'h00, 8'hF7, 8'hFF, 8'hFF},
    {8'h25, 1'b0, 8'h00, 8'hD7, 8'hFF, 8'hFF},
    {8'h33, 1'b0, 8'h00, 8'hDF, 8'hFF, 8'hFF},
    {8'h47, 1'b0, 8'h00, 8'hDF, 8'h7F, 8'hFF},
    {8'h40, 1'b0, 8'h00, 8'hDF, 8'h7E, 8'hFF},
    {8'h57, 1'b0, 8'h00, 8'hDF, 8'hFE, 8'hFF},
    {8'h62, 1'b0, 8'h00, 8'hDF, 8'hFE, 8'hFB},
    {8'h76, 1'b0, 8'h00, 8'hDF, 8'hFE, 8'hFB},
    {8'hFF, 1'b0, 8'h00, 8'hDF, 8'hFE, 8'hFB},
    {8'h00, 1'b0, 8'h00, 8'hDF, 8'hFE, 8'hFB}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] frame(input logic hasRep, input logic [7:0] d);
    return hasRep ? {1'b1, d, 1'b0} : 10'h3FF;
  endfunction

  // sends one command; obs[k] is serOut after edges E8+k; optional noise frame during reply
  task automatic doCmd(input logic [7:0] op, input bit noisy, input logic [7:0] noise,
                       output logic [9:0] obs);
    logic [9:0] nf;
    nf = {1'b1, noise, 1'b0};
    @(negedge clk) serIn = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) serIn = op[i];
    end
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      serIn  = noisy ? nf[k] : 1'b1;
      obs[k] = serOut;
    end
    serIn = 1'b1;
  endtask

  task automatic pulse(input logic [3:0] m); // {jab, loop, sqe, rate}
    @(negedge clk);
    {jabberEv, auiLoopErrEv, auiSqeEv, auiRateErrEv} = m;
    @(negedge clk);
    {jabberEv, auiLoopErrEv, auiSqeEv, auiRateErrEv} = 4'b0;
  endtask

  task automatic readExpect(input string req, input logic [7:0] op, input logic [7:0] d);
    logic [9:0] o;
    doCmd(op, 1'b0, 8'h00, o);
    check(req, o, frame(1'b1, d));
  endtask

  task automatic checkResetState(input string tag);
    check({tag, " tpEnable"}, tpEnable, 8'hFF);
    check({tag, " linkTest"}, tpLinkTestEn, 8'hFF);
    check({tag, " autoPol"}, tpAutoPolEn, 8'hFF);
    check({tag, " aui/alt/opt/serOut"},
          {auiEnable, auiAltRecon, tpAltRecon, optionBits, serOut}, {1'b1, 1'b0, 1'b0, 3'b000, 1'b1});
  endtask

  initial begin
    logic [9:0] o;
    logic [40:0] row;
    string tag;
    serIn = 1'b1; rstN = 1'b0;
    tpLinkGood = 8'hA5; tpPolRev = 8'h3C; tpConnected = 8'hF0; tpRateErr = 8'h81;
    auiPartitioned = 1'b0; auiRateErrEv = 1'b0; auiSqeEv = 1'b0; auiLoopErrEv = 1'b0; jabberEv = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkResetState("R12 after reset");

    // table walk: R3 reads, R4 port enables, R5 link-test/auto-polarity, R13 unknown
    for (int i = 0; i < NVEC; i++) begin
      row = VEC[i];
      tag = (i < 4) ? "R3" : (i < 7) ? "R4" : (i < 12) ? "R5" : "R13";
      doCmd(row[40:33], 1'b0, 8'h00, o);
      check({tag, " reply frame"}, o, frame(row[32], row[31:24]));
      check({tag, " tpEnable"}, tpEnable, row[23:16]);
      check({tag, " linkTest"}, tpLinkTestEn, row[15:8]);
      check({tag, " autoPol"}, tpAutoPolEn, row[7:0]);
    end

    // R1 bit order: 0x0D written LSB first gives 101; MSB-first order would be unknown 0xB0
    doCmd(8'h0D, 1'b0, 8'h00, o);
    check("R1 R11 option write", optionBits, 3'b101);
    doCmd(8'h0A, 1'b0, 8'h00, o);
    check("R11 option rewrite", optionBits, 3'b010);

    // R6
    doCmd(8'h2F, 1'b0, 8'h00, o);
    check("R6 aui disable", auiEnable, 1'b0);
    doCmd(8'h3F, 1'b0, 8'h00, o);
    check("R6 aui enable", auiEnable, 1'b1);

    // R7
    doCmd(8'h1F, 1'b0, 8'h00, o);
    check("R7 aui alt", {auiAltRecon, tpAltRecon}, 2'b10);
    doCmd(8'h10, 1'b0, 8'h00, o);
    check("R7 tp alt", {auiAltRecon, tpAltRecon}, 2'b11);
    doCmd(8'hD0, 1'b0, 8'h00, o);
    check("R7 alt stays", {auiAltRecon, tpAltRecon}, 2'b11);

    // R8 / R9 AUI status and clear masks
    auiPartitioned = 1'b1;
    pulse(4'b0111);
    readExpect("R8 aui status all set", 8'h89, 8'hF0);
    readExpect("R9 0x89 clears nothing", 8'h89, 8'hF0);
    readExpect("R9 0x8D read", 8'h8D, 8'hF0);
    readExpect("R9 0x8D cleared rate only", 8'h89, 8'hB0);
    readExpect("R9 0x8B read", 8'h8B, 8'hB0);
    readExpect("R9 0x8B cleared sqe/loop", 8'h89, 8'h80);
    pulse(4'b0111);
    readExpect("R9 0x8F read", 8'h8F, 8'hF0);
    readExpect("R9 0x8F cleared three, partition kept", 8'h89, 8'h80);
    auiPartitioned = 1'b0;
    readExpect("R8 partition follows input", 8'h89, 8'h00);

    // R10 jabber
    pulse(4'b1000);
    readExpect("R10 jabber set", 8'hF0, 8'h80);
    readExpect("R10 jabber cleared", 8'hF0, 8'h00);

    // R2 input ignored during reply: noise frame would disable port 0 (0x20)
    doCmd(8'hE0, 1'b1, 8'h20, o);
    check("R2 reply with noise", o, frame(1'b1, 8'h3C));
    check("R2 noise ignored", tpEnable, 8'hDF);
    doCmd(8'hFF, 1'b0, 8'h00, o);
    check("R2 line rests high", o, 10'h3FF);

    // R12 reset again
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkResetState("R12 second reset");

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule